// File: doc/BRIEF.md
# Linked-Pair Descriptor Chain Walker

The walker drives one channel of a linked-list memory copy engine. Software places transfer descriptors in memory in pairs. Each pair has a source descriptor and a destination descriptor, and each descriptor carries its own pointer to the next one. Software then hands the walker the address of the first source descriptor and the first destination descriptor, and pulses `start`. The pulse has effect only while the scatter-gather mode input is high.

The walker reads each descriptor through a 32-bit read port with a request/response handshake. For each pair it hands one command to a downstream copier and waits for the copier to report completion. It then either follows both next pointers or stops, depending on the stop flag.

Every finished pair produces a one-cycle pulse. A completion-interrupt pulse is added when a descriptor asks for one. The end of the chain produces a final pulse. A read error during a fetch abandons the walk and reports whether a source or a destination fetch failed.

The sequencer has these states:
- S_IDLE: waiting for `start`.
- S_LOAD_SRC and S_LOAD_DST: one cycle each, launching a fetch.
- S_FETCH_SRC and S_FETCH_DST: waiting for the fetch to finish.
- S_ISSUE: presenting the copier command.
- S_WAIT_COPY: waiting for `copy_done`.
- S_RETIRE: one cycle that emits the pulses.

The sequencer moves between them as follows:
- S_IDLE goes to S_LOAD_SRC on `start` when `sg_mode` is high.
- S_LOAD_SRC goes to S_FETCH_SRC, and S_LOAD_DST goes to S_FETCH_DST.
- S_FETCH_SRC goes to S_LOAD_DST when the fetch finishes, or to S_IDLE on a read error.
- S_FETCH_DST goes to S_ISSUE, or to S_RETIRE if the size is zero, or to S_IDLE on a read error.
- S_ISSUE goes to S_WAIT_COPY when the copier accepts the command.
- S_WAIT_COPY goes to S_RETIRE on `copy_done`.
- S_RETIRE goes to S_IDLE if the stop flag is set, otherwise back to S_LOAD_SRC.

The fetch unit has three states: F_IDLE, F_REQ and F_WAIT. It moves from F_IDLE to F_REQ when launched, from F_REQ to F_WAIT when the request is accepted, and from F_WAIT either back to F_REQ for the next word or to F_IDLE after the last word or an error.

Top module: `sg_chain_walker`

## Requirements
- R1: Out of reset the walker is idle, with no request, command or pulse active. A `start` pulse begins a walk only when `sg_mode` is high. With `sg_mode` low, `start` causes no read and `busy` stays low.
- R2: A descriptor is 32 bytes, fetched as six 32-bit words at byte offsets 0, 4, 8, 12, 16 and 20, in that order:
  - offsets 0 and 4: buffer address, low word then high word;
  - offset 8: size;
  - offset 12: control;
  - offsets 16 and 20: next-descriptor address, low word then high word.
  The words at offsets 24 and 28 are never read. The source descriptor of a pair is fetched before the destination descriptor.
- R3: For each pair with a nonzero size, exactly one copier command is issued. It carries the source buffer address, the destination buffer address and a length taken from the source size field. The command holds steady until `cmd_ready`.
- R4: After a command is accepted, the walker issues nothing further until `copy_done`. `pair_done` pulses for one cycle exactly once per completed pair.
- R5: A pair whose size is zero completes without a copier command and still produces its `pair_done` pulse.
- R6: A size above MAX_LEN (default 0x40000000) is issued as a length of exactly MAX_LEN.
- R7: If bit 4 (value 0x10) of either control word of a pair is set, the chain ends after that pair. `chain_done` pulses together with that pair's `pair_done`, and the walker returns to idle.
- R8: When neither stop bit is set, the next source and destination descriptors are fetched from the 64-bit next fields of the current source and destination descriptors respectively.
- R9: `irq` pulses together with `pair_done` when bit 2 (value 0x4) of either control word of the pair is set. Control bits 0, 1 and 3 have no effect.
- R10: A read error during a source-descriptor fetch pulses `src_err`, issues no command for that pair and returns the walker to idle.
- R11: A read error during a destination-descriptor fetch pulses `dst_err`, issues no command for that pair and returns the walker to idle.
- R12: Once `rd_req_valid` is raised, it and `rd_req_addr` hold until `rd_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sg_mode | input | 1 | Scatter-gather mode select; walk disabled when low |
| start | input | 1 | One-cycle enable strobe |
| src_head | input | ADDR_W | First source descriptor address |
| dst_head | input | ADDR_W | First destination descriptor address |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Byte address of the 32-bit word to read |
| rd_resp_valid | input | 1 | Read response valid |
| rd_resp_data | input | 32 | Read response data |
| rd_resp_err | input | 1 | Read response error |
| cmd_valid | output | 1 | Copier command valid |
| cmd_ready | input | 1 | Copier accepts command |
| cmd_src | output | ADDR_W | Source buffer address |
| cmd_dst | output | ADDR_W | Destination buffer address |
| cmd_len | output | 32 | Bytes to copy |
| copy_done | input | 1 | Copier finished the current command |
| pair_done | output | 1 | Pulse per completed pair |
| irq | output | 1 | Completion-interrupt pulse |
| chain_done | output | 1 | Pulse when the chain ends on a stop flag |
| src_err | output | 1 | Pulse on source descriptor read error |
| dst_err | output | 1 | Pulse on destination descriptor read error |
| busy | output | 1 | Walker not idle |

## Verification
The bench places chains out of address order in memory. A walker that stepped to the adjacent slot instead of following the next pointers would send the copier commands in the wrong sequence.

Zero sizes, sizes just above and far above MAX_LEN, and stop or interrupt flags set in only one of the two control words are all mixed in. These catch a design that issues an empty copy, wraps the length instead of clamping it, or looks at only one descriptor's flags.

Read errors are injected partway through both source and destination fetches, while random read and copier latencies check that requests and commands stay stable and that no second command appears before `copy_done`.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int WORD_W      = 32;
    localparam int DESC_BYTES  = 32;
    localparam int FETCH_WORDS = 6;                   // words 6 and 7 are reserved
    localparam int IDX_W       = $clog2(FETCH_WORDS);
    localparam int CTRL_STOP   = 4;
    localparam int CTRL_IRQ    = 2;

    typedef struct packed {
        logic [63:0] nxt;
        logic        stop;
        logic        irq;
        logic [31:0] size;
        logic [63:0] buf_addr;
    } sgw_desc_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD_SRC,
        S_FETCH_SRC,
        S_LOAD_DST,
        S_FETCH_DST,
        S_ISSUE,
        S_WAIT_COPY,
        S_RETIRE
    } seq_state_t;
endpackage

// File: rtl/sgw_desc_fetch.sv
module sgw_desc_fetch
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_resp_valid,
    input  logic [WORD_W-1:0] rd_resp_data,
    input  logic              rd_resp_err,
    output logic              done,
    output logic              err,
    output sgw_desc_t         desc
);
    typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fetch_state_t;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FETCH_WORDS - 1);

    fetch_state_t      fst;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] base_q;
    logic              capture;

    // State register and handshake bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fst    <= F_IDLE;
            idx    <= '0;
            base_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (fst)
                F_IDLE: if (go) begin
                    base_q <= base;
                    idx    <= '0;
                    fst    <= F_REQ;
                end
                F_REQ: if (rd_req_ready) fst <= F_WAIT;
                F_WAIT: if (rd_resp_valid) begin
                    if (rd_resp_err) begin
                        err <= 1'b1;
                        fst <= F_IDLE;
                    end else if (idx == LAST_IDX) begin
                        done <= 1'b1;
                        fst  <= F_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                        fst <= F_REQ;
                    end
                end
                default: fst <= F_IDLE;
            endcase
        end
    end

    assign capture = (fst == F_WAIT) && rd_resp_valid && !rd_resp_err;

    // Field assembly: each word lands in its own field
    always_ff @(posedge clk) begin
        if (capture) begin
            case (idx)
                3'd0:    desc.buf_addr[31:0]  <= rd_resp_data;
                3'd1:    desc.buf_addr[63:32] <= rd_resp_data;
                3'd2:    desc.size            <= rd_resp_data;
                3'd3: begin
                    desc.stop <= rd_resp_data[CTRL_STOP];
                    desc.irq  <= rd_resp_data[CTRL_IRQ];
                end
                3'd4:    desc.nxt[31:0]       <= rd_resp_data;
                default: desc.nxt[63:32]      <= rd_resp_data;
            endcase
        end
    end

    always_comb begin
        rd_req_valid = (fst == F_REQ);
        rd_req_addr  = base_q + ADDR_W'({idx, 2'b00});
    end
endmodule

// File: rtl/sgw_sequencer.sv
module sgw_sequencer
    import sgw_pkg::*;
#(
    parameter int          ADDR_W  = 64,
    parameter int unsigned MAX_LEN = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sg_mode,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_head,
    input  logic [ADDR_W-1:0] dst_head,
    input  logic              f_done,
    input  logic              f_err,
    input  sgw_desc_t         f_desc,
    output logic              f_go,
    output logic [ADDR_W-1:0] f_base,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_src,
    output logic [ADDR_W-1:0] cmd_dst,
    output logic [31:0]       cmd_len,
    input  logic              copy_done,
    output logic              pair_done,
    output logic              irq,
    output logic              chain_done,
    output logic              src_err,
    output logic              dst_err,
    output logic              busy
);
    localparam logic [31:0] LEN_CAP = 32'(MAX_LEN);

    seq_state_t        st, nst;
    logic [ADDR_W-1:0] cur_src, cur_dst;
    logic [ADDR_W-1:0] src_buf, dst_buf, src_nxt, dst_nxt;
    logic [31:0]       src_len;
    logic              src_stop, dst_stop, src_irq, dst_irq;
    logic              stop_any;

    assign stop_any = src_stop | dst_stop;

    // Next-state decision
    always_comb begin
        nst = st;
        unique case (st)
            S_IDLE:      if (start && sg_mode) nst = S_LOAD_SRC;
            S_LOAD_SRC:  nst = S_FETCH_SRC;
            S_FETCH_SRC: if (f_err) nst = S_IDLE;
                         else if (f_done) nst = S_LOAD_DST;
            S_LOAD_DST:  nst = S_FETCH_DST;
            S_FETCH_DST: if (f_err) nst = S_IDLE;
                         else if (f_done) nst = (src_len == 32'd0) ? S_RETIRE : S_ISSUE;
            S_ISSUE:     if (cmd_ready) nst = S_WAIT_COPY;
            S_WAIT_COPY: if (copy_done) nst = S_RETIRE;
            S_RETIRE:    nst = stop_any ? S_IDLE : S_LOAD_SRC;
            default:     nst = S_IDLE;
        endcase
    end

    // State register and per-pair context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            cur_src  <= '0;
            cur_dst  <= '0;
            src_buf  <= '0;
            dst_buf  <= '0;
            src_nxt  <= '0;
            dst_nxt  <= '0;
            src_len  <= '0;
            src_stop <= 1'b0;
            dst_stop <= 1'b0;
            src_irq  <= 1'b0;
            dst_irq  <= 1'b0;
        end else begin
            st <= nst;
            if (st == S_IDLE && start && sg_mode) begin
                cur_src <= src_head;
                cur_dst <= dst_head;
            end
            if (st == S_FETCH_SRC && f_done) begin
                src_buf  <= ADDR_W'(f_desc.buf_addr);
                src_nxt  <= ADDR_W'(f_desc.nxt);
                src_len  <= f_desc.size;
                src_stop <= f_desc.stop;
                src_irq  <= f_desc.irq;
            end
            if (st == S_FETCH_DST && f_done) begin
                dst_buf  <= ADDR_W'(f_desc.buf_addr);
                dst_nxt  <= ADDR_W'(f_desc.nxt);
                dst_stop <= f_desc.stop;
                dst_irq  <= f_desc.irq;
            end
            if (st == S_RETIRE && !stop_any) begin
                cur_src <= src_nxt;
                cur_dst <= dst_nxt;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        f_go       = (st == S_LOAD_SRC) || (st == S_LOAD_DST);
        f_base     = (st == S_LOAD_DST) ? cur_dst : cur_src;
        cmd_valid  = (st == S_ISSUE);
        cmd_src    = src_buf;
        cmd_dst    = dst_buf;
        cmd_len    = (src_len > LEN_CAP) ? LEN_CAP : src_len;
        pair_done  = (st == S_RETIRE);
        irq        = (st == S_RETIRE) && (src_irq | dst_irq);
        chain_done = (st == S_RETIRE) && stop_any;
        src_err    = (st == S_FETCH_SRC) && f_err;
        dst_err    = (st == S_FETCH_DST) && f_err;
        busy       = (st != S_IDLE);
    end
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
    import sgw_pkg::*;
#(
    parameter int          ADDR_W  = 64,
    parameter int unsigned MAX_LEN = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sg_mode,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_head,
    input  logic [ADDR_W-1:0] dst_head,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_resp_valid,
    input  logic [31:0]       rd_resp_data,
    input  logic              rd_resp_err,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_src,
    output logic [ADDR_W-1:0] cmd_dst,
    output logic [31:0]       cmd_len,
    input  logic              copy_done,
    output logic              pair_done,
    output logic              irq,
    output logic              chain_done,
    output logic              src_err,
    output logic              dst_err,
    output logic              busy
);
    logic              f_go, f_done, f_err;
    logic [ADDR_W-1:0] f_base;
    sgw_desc_t         f_desc;

    sgw_desc_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (f_go),
        .base         (f_base),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_addr  (rd_req_addr),
        .rd_resp_valid(rd_resp_valid),
        .rd_resp_data (rd_resp_data),
        .rd_resp_err  (rd_resp_err),
        .done         (f_done),
        .err          (f_err),
        .desc         (f_desc)
    );

    sgw_sequencer #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sg_mode   (sg_mode),
        .start     (start),
        .src_head  (src_head),
        .dst_head  (dst_head),
        .f_done    (f_done),
        .f_err     (f_err),
        .f_desc    (f_desc),
        .f_go      (f_go),
        .f_base    (f_base),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_src   (cmd_src),
        .cmd_dst   (cmd_dst),
        .cmd_len   (cmd_len),
        .copy_done (copy_done),
        .pair_done (pair_done),
        .irq       (irq),
        .chain_done(chain_done),
        .src_err   (src_err),
        .dst_err   (dst_err),
        .busy      (busy)
    );
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
    parameter int          ADDR_W  = 64,
    parameter int unsigned MAX_LEN = 32'h4000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sg_mode,
    input logic              start,
    input logic              busy,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_src,
    input logic [ADDR_W-1:0] cmd_dst,
    input logic [31:0]       cmd_len,
    input logic              pair_done,
    input logic              irq,
    input logic              chain_done,
    input logic              src_err,
    input logic              dst_err
);
    assert_mode_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !sg_mode) |=> !busy);

    assert_no_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_addr[4:2] < 3'd6));

    assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_src) && $stable(cmd_dst) && $stable(cmd_len)));

    assert_one_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_valid);

    // R5: zero sizes never reach the copier
    assert_len_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_len != 32'd0 && cmd_len <= 32'(MAX_LEN)));

    assert_end_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |-> pair_done ##1 !busy);

    assert_irq_with_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pair_done);

    assert_src_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        src_err |=> !busy);

    assert_dst_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dst_err |=> !busy);

    assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({src_err, dst_err, pair_done}));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
endmodule

bind sg_chain_walker sgw_checker #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) u_sgw_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sg_mode     (sg_mode),
    .start       (start),
    .busy        (busy),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_req_addr (rd_req_addr),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_src     (cmd_src),
    .cmd_dst     (cmd_dst),
    .cmd_len     (cmd_len),
    .pair_done   (pair_done),
    .irq         (irq),
    .chain_done  (chain_done),
    .src_err     (src_err),
    .dst_err     (dst_err)
);

// File: tb/sg_chain_walker_test.sv
`timescale 1ns/1ps
module sg_chain_walker_test;
    localparam int unsigned MAXL = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sg_mode = 1'b1;
    logic        start = 1'b0;
    logic [63:0] src_head = '0, dst_head = '0;
    logic        rd_req_valid, rd_req_ready = 1'b0;
    logic [63:0] rd_req_addr;
    logic        rd_resp_valid = 1'b0, rd_resp_err = 1'b0;
    logic [31:0] rd_resp_data = '0;
    logic        cmd_valid, cmd_ready = 1'b0;
    logic [63:0] cmd_src, cmd_dst;
    logic [31:0] cmd_len;
    logic        copy_done = 1'b0;
    logic        pair_done, irq, chain_done, src_err, dst_err, busy;

    sg_chain_walker #(.ADDR_W(64), .MAX_LEN(MAXL)) uut (.*);

    always #4 clk = ~clk;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Memory model
    logic [31:0] mem [0:1023];
    logic [63:0] err_addr = '1;
    int          n_reads = 0;
    int          exp_off = 0;
    bit          pend = 0;
    int          dly = 0;
    logic [63:0] paddr = '0;
    bit          prev_wait = 0;
    logic [63:0] prev_addr = '0;

    initial begin
        forever begin
            @(negedge clk);
            rd_resp_valid = 1'b0;
            rd_resp_err   = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    rd_resp_valid = 1'b1;
                    rd_resp_data  = mem[paddr[11:2]];
                    rd_resp_err   = (paddr == err_addr);
                    pend = 0;
                end else dly--;
            end
            rd_req_ready = (!pend && !rd_resp_valid) ? ($urandom % 4 != 0) : 1'b0;
            #1;
            if (prev_wait)
                chk(rd_req_valid && rd_req_addr == prev_addr, "R12 request held", rd_req_addr, prev_addr);
            prev_wait = rd_req_valid && !rd_req_ready;
            prev_addr = rd_req_addr;
            if (rd_req_valid && rd_req_ready) begin
                n_reads++;
                chk(rd_req_addr[4:0] == 5'(exp_off), "R2 word order", rd_req_addr[4:0], 64'(exp_off));
                exp_off = (exp_off == 20) ? 0 : exp_off + 4;
                pend  = 1;
                paddr = rd_req_addr;
                dly   = $urandom % 3;
            end
        end
    end

    // Copier model
    logic [63:0] e_src [0:7];
    logic [63:0] e_dst [0:7];
    logic [31:0] e_len [0:7];
    int e_ncmd = 0, cmd_idx = 0;
    bit cpend = 0;
    int cdly = 0;

    initial begin
        forever begin
            @(negedge clk);
            copy_done = 1'b0;
            if (cpend) begin
                if (cdly == 0) begin
                    copy_done = 1'b1;
                    cpend = 0;
                end else cdly--;
            end
            cmd_ready = (!cpend && !copy_done) ? ($urandom % 3 != 0) : 1'b0;
            #1;
            if ((cpend || copy_done) && cmd_valid)
                chk(0, "R4 command before copy_done", 64'(cmd_valid), 64'd0);
            if (cmd_valid && cmd_ready) begin
                if (cmd_idx < e_ncmd) begin
                    chk(cmd_src == e_src[cmd_idx], "R3 R8 command source", cmd_src, e_src[cmd_idx]);
                    chk(cmd_dst == e_dst[cmd_idx], "R3 R8 command destination", cmd_dst, e_dst[cmd_idx]);
                    chk(cmd_len == e_len[cmd_idx], "R3 R6 command length", 64'(cmd_len), 64'(e_len[cmd_idx]));
                end else begin
                    chk(0, "R3 R5 unexpected command", 64'(cmd_idx), 64'(e_ncmd));
                end
                cmd_idx++;
                cpend = 1;
                cdly  = $urandom % 4;
            end
        end
    end

    // Pulse monitor
    int n_pair = 0, n_irq = 0, n_chain = 0, n_serr = 0, n_derr = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (pair_done)  n_pair++;
            if (irq)        n_irq++;
            if (chain_done) n_chain++;
            if (src_err)    n_serr++;
            if (dst_err)    n_derr++;
        end
    end

    // Chain description
    int          slot   [0:7];
    logic [63:0] p_sbuf [0:7];
    logic [63:0] p_dbuf [0:7];
    logic [31:0] p_size [0:7];
    logic [31:0] p_sctrl[0:7];
    logic [31:0] p_dctrl[0:7];
    int e_pairs, e_irq, e_chain, e_serr, e_derr;

    function automatic logic [31:0] exp_len(input logic [31:0] sz);
        return (sz > MAXL) ? MAXL : sz;
    endfunction

    task automatic put_desc(input int a, input logic [63:0] b, input logic [31:0] sz,
                            input logic [31:0] ctl, input logic [63:0] nx);
        mem[a/4 + 0] = b[31:0];
        mem[a/4 + 1] = b[63:32];
        mem[a/4 + 2] = sz;
        mem[a/4 + 3] = ctl;
        mem[a/4 + 4] = nx[31:0];
        mem[a/4 + 5] = nx[63:32];
        mem[a/4 + 6] = 32'hDEAD_0000 | 32'(a);
        mem[a/4 + 7] = $urandom;
    endtask

    task automatic load_chain(input int n);
        e_ncmd = 0; e_irq = 0; e_pairs = n; e_chain = 1; e_serr = 0; e_derr = 0;
        for (int k = 0; k < n; k++) begin
            int sa = slot[k] * 64;
            logic [63:0] ns = (k < n - 1) ? 64'(slot[k+1] * 64) : 64'h0;
            logic [63:0] nd = (k < n - 1) ? ns + 64'd32 : 64'h0;
            put_desc(sa, p_sbuf[k], p_size[k], p_sctrl[k], ns);
            put_desc(sa + 32, p_dbuf[k], p_size[k], p_dctrl[k], nd);
            if (p_size[k] != 0) begin
                e_src[e_ncmd] = p_sbuf[k];
                e_dst[e_ncmd] = p_dbuf[k];
                e_len[e_ncmd] = exp_len(p_size[k]);
                e_ncmd++;
            end
            if (p_sctrl[k][2] || p_dctrl[k][2]) e_irq++;
        end
        src_head = 64'(slot[0] * 64);
        dst_head = src_head + 64'd32;
    endtask

    task automatic run_walk(input string tag);
        n_pair = 0; n_irq = 0; n_chain = 0; n_serr = 0; n_derr = 0;
        cmd_idx = 0; exp_off = 0; n_reads = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk); #2;
            if (n_chain != 0 || n_serr != 0 || n_derr != 0) break;
        end
        repeat (4) @(negedge clk);
        #2;
        chk(!busy, {tag, " R7 idle after walk"}, 64'(busy), 64'd0);
        chk(n_pair == e_pairs, {tag, " R4 pair_done count"}, 64'(n_pair), 64'(e_pairs));
        chk(cmd_idx == e_ncmd, {tag, " R3 R5 command count"}, 64'(cmd_idx), 64'(e_ncmd));
        chk(n_irq == e_irq, {tag, " R9 irq count"}, 64'(n_irq), 64'(e_irq));
        chk(n_chain == e_chain, {tag, " R7 chain_done count"}, 64'(n_chain), 64'(e_chain));
        chk(n_serr == e_serr, {tag, " R10 src_err count"}, 64'(n_serr), 64'(e_serr));
        chk(n_derr == e_derr, {tag, " R11 dst_err count"}, 64'(n_derr), 64'(e_derr));
    endtask

    task automatic set_pair(input int k, input int s, input logic [31:0] sz,
                            input logic [31:0] sc, input logic [31:0] dc);
        slot[k]    = s;
        p_sbuf[k]  = {32'h1000_0000 + 32'(k), 32'hA000_0000 + 32'(k * 256)};
        p_dbuf[k]  = {32'h2000_0000 + 32'(k), 32'hB000_0000 + 32'(k * 256)};
        p_size[k]  = sz;
        p_sctrl[k] = sc;
        p_dctrl[k] = dc;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #2;
        chk(!busy && !rd_req_valid && !cmd_valid && !pair_done && !chain_done && !irq,
            "R1 reset state", {59'd0, busy, rd_req_valid, cmd_valid, pair_done, chain_done}, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // Three pairs, out of order; irq bit on src of pair 1 and dst of pair 2
        set_pair(0, 3,  32'h100,  32'h2,  32'h1);
        set_pair(1, 10, 32'h40,   32'h6,  32'h0);
        set_pair(2, 5,  32'h1000, 32'h10, 32'h14);
        load_chain(3);
        run_walk("basic");

        // Zero size in the middle (R5)
        set_pair(0, 20, 32'h80, 32'h0, 32'h0);
        set_pair(1, 7,  32'h0,  32'h4, 32'h0);
        set_pair(2, 33, 32'h20, 32'h0, 32'h10);
        load_chain(3);
        run_walk("R5 zero-middle");

        // Single zero-size pair with stop (R5 R7)
        set_pair(0, 40, 32'h0, 32'h10, 32'h10);
        load_chain(1);
        run_walk("R5 zero-single");

        // Clamp (R6); stop only in dst control word (R7)
        set_pair(0, 12, 32'h4000_0000, 32'hB, 32'h3);
        set_pair(1, 2,  32'h4000_0001, 32'h0, 32'h0);
        set_pair(2, 50, 32'hFFFF_FFFF, 32'h0, 32'h10);
        load_chain(3);
        run_walk("R6 clamp");

        // Source fetch error on pair 1 (R10)
        set_pair(0, 9,  32'h44, 32'h4, 32'h0);
        set_pair(1, 17, 32'h55, 32'h0, 32'h0);
        set_pair(2, 25, 32'h66, 32'h0, 32'h10);
        load_chain(3);
        err_addr = 64'(17 * 64 + 12);
        e_pairs = 1; e_ncmd = 1; e_irq = 1; e_chain = 0; e_serr = 1;
        run_walk("R10 src error");
        err_addr = '1;

        // Destination fetch error on pair 0 (R11)
        set_pair(0, 30, 32'h44, 32'h4, 32'h0);
        set_pair(1, 31, 32'h55, 32'h0, 32'h10);
        load_chain(2);
        err_addr = 64'(30 * 64 + 32 + 20);
        e_pairs = 0; e_ncmd = 0; e_irq = 0; e_chain = 0; e_derr = 1;
        run_walk("R11 dst error");
        err_addr = '1;

        // Mode gate off (R1)
        set_pair(0, 1, 32'h10, 32'h10, 32'h10);
        load_chain(1);
        sg_mode = 1'b0;
        n_reads = 0; n_pair = 0; cmd_idx = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        #2;
        chk(n_reads == 0, "R1 no read with mode off", 64'(n_reads), 64'd0);
        chk(!busy && n_pair == 0 && cmd_idx == 0, "R1 idle with mode off", 64'(busy), 64'd0);
        sg_mode = 1'b1;

        // Constrained random chains
        for (int it = 0; it < 30; it++) begin
            int n = 1 + $urandom % 6;
            int off = $urandom % 64;
            int stride = 1 + 2 * ($urandom % 8);
            for (int k = 0; k < n; k++) begin
                logic [31:0] sz;
                case ($urandom % 4)
                    0: sz = 32'h0;
                    1: sz = 32'(1 + $urandom % 256);
                    2: sz = MAXL + 32'($urandom % 1000);
                    default: sz = $urandom;
                endcase
                set_pair(k, (off + k * stride) % 64, sz, $urandom & 32'hF, $urandom & 32'hF);
                p_sbuf[k] = {$urandom, $urandom};
                p_dbuf[k] = {$urandom, $urandom};
            end
            case ($urandom % 3)
                0: p_sctrl[n-1] = p_sctrl[n-1] | 32'h10;
                1: p_dctrl[n-1] = p_dctrl[n-1] | 32'h10;
                default: begin
                    p_sctrl[n-1] = p_sctrl[n-1] | 32'h10;
                    p_dctrl[n-1] = p_dctrl[n-1] | 32'h10;
                end
            endcase
            load_chain(n);
            run_walk("random R8");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule